// File: doc/BRIEF.md
# Status Flags and Conditional Flow Unit

This unit holds the eight processor status flags and works out where the program counter goes for conditional branches and skips. During each cycle the core can present an ALU flag update through a per-bit write mask. It can also force a single flag to 1 or to 0, copy a register bit into the transfer flag, or signal a return from interrupt. For a bit-load, the unit returns a register byte in which one selected bit has been replaced by the transfer flag.

The next program counter is combinational. It is computed from the current program counter and the flag values held at the start of the cycle. A branch carries a flag selector, a polarity and a signed 7-bit displacement. It can instead ask for the signed-compare condition, which is derived from the negative and overflow flags. A skip carries a tested bit value, a polarity, and whether the following instruction is one word or two words long. The unit also reports whether the instruction costs 1 cycle or 2.

Top module: `sreg_branch_unit`

## Requirements
- R1: After reset the status byte reads 0x00. With no branch or skip request, `pc_next` equals `pc_in + 1` (modulo 2^PC_W) and `cycles` equals 1.
- R2: The flag positions in the status byte are: C bit 0, Z bit 1, N bit 2, V bit 3, S bit 4, H bit 5, T bit 6, I bit 7. On a clock edge, every bit with a 1 in `alu_mask` takes its value from `alu_flags`. Every other bit keeps its value.
- R3: `flag_set` forces bit `flag_sel` to 1 and `flag_clr` forces it to 0. `flag_set` wins when both are asserted. Either one overrides the ALU mask, the transfer-flag store and the interrupt return on that bit.
- R4: `tsave_req` writes `tsave_val` into T (bit 6), and this overrides the ALU mask. `tfill_out` always equals `tfill_in` with bit `tfill_pos` replaced by the current T. It writes no flag.
- R5: `iret` sets I (bit 7) on the clock edge.
- R6: A branch with `br_nv` low tests bit `br_sel` of the current status byte. It is taken when that bit equals `br_when_set`. A taken branch gives `pc_in + 1 + sext(br_off)` modulo 2^PC_W and `cycles` = 2. A branch that is not taken gives `pc_in + 1` and `cycles` = 1.
- R7: A branch with `br_nv` high ignores `br_sel` and tests N xor V, whatever value the stored S bit holds. Signed greater-or-equal is `br_when_set`=0 and signed less-than is `br_when_set`=1.
- R8: A skip is taken when `sk_bit` equals `sk_when_set`. A taken skip gives `pc_in + 2`, or `pc_in + 3` when `sk_long` is high, with `cycles` = 2. A skip that is not taken gives `pc_in + 1` with `cycles` = 1.
- R9: When `br_req` and `sk_req` are both high, the skip request is ignored and the result follows R6/R7 alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_mask | input | 8 | Per-flag write enable for the ALU update |
| alu_flags | input | 8 | Flag values produced by the ALU |
| flag_set | input | 1 | Force selected flag to 1 |
| flag_clr | input | 1 | Force selected flag to 0 |
| flag_sel | input | 3 | Flag index for set/clear |
| tsave_req | input | 1 | Store a register bit into T |
| tsave_val | input | 1 | Bit value to store into T |
| tfill_in | input | 8 | Register byte for bit-load |
| tfill_pos | input | 3 | Bit position replaced by T |
| tfill_out | output | 8 | Register byte with T inserted |
| iret | input | 1 | Interrupt return strobe, sets I |
| br_req | input | 1 | Conditional branch request |
| br_nv | input | 1 | Test N xor V instead of a flag |
| br_when_set | input | 1 | Branch polarity: 1 taken on set, 0 on clear |
| br_sel | input | 3 | Flag index tested by the branch |
| br_off | input | OFF_W | Signed branch displacement |
| sk_req | input | 1 | Skip request |
| sk_bit | input | 1 | Tested bit value |
| sk_when_set | input | 1 | Skip polarity: 1 skip on set, 0 on clear |
| sk_long | input | 1 | Following instruction is two words |
| pc_in | input | PC_W | Address of the current instruction |
| pc_next | output | PC_W | Next program counter |
| cycles | output | 2 | Cycle cost, 1 or 2 |
| sreg | output | 8 | Current status flags |

## Verification
The hardest case to reach is a stored S bit that disagrees with N xor V. The ALU path normally writes these flags consistently, so the stimulus first loads N and V through the mask and then drives S to the opposite value. That value shows whether signed branches really use N xor V. Write conflicts on a single flag are also set up on purpose in one cycle: set against clear, set or clear against the ALU mask, the T store and the interrupt return. Branch displacements at both ends of the signed range are applied at program counters next to the wrap points.

// File: rtl/sreg_branch_unit.sv
module sreg_branch_unit #(
  parameter int PC_W  = 10,
  parameter int OFF_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       alu_mask,
  input  logic [7:0]       alu_flags,
  input  logic             flag_set,
  input  logic             flag_clr,
  input  logic [2:0]       flag_sel,
  input  logic             tsave_req,
  input  logic             tsave_val,
  input  logic [7:0]       tfill_in,
  input  logic [2:0]       tfill_pos,
  output logic [7:0]       tfill_out,
  input  logic             iret,
  input  logic             br_req,
  input  logic             br_nv,
  input  logic             br_when_set,
  input  logic [2:0]       br_sel,
  input  logic [OFF_W-1:0] br_off,
  input  logic             sk_req,
  input  logic             sk_bit,
  input  logic             sk_when_set,
  input  logic             sk_long,
  input  logic [PC_W-1:0]  pc_in,
  output logic [PC_W-1:0]  pc_next,
  output logic [1:0]       cycles,
  output logic [7:0]       sreg
);
  localparam int I_POS = 7;
  localparam int T_POS = 6;
  localparam int V_POS = 3;
  localparam int N_POS = 2;
  localparam int EXT_W = PC_W - OFF_W;

  logic [7:0]      flags_q, flags_d;
  logic            br_flag, br_take, sk_take;
  logic [PC_W-1:0] off_ext, pc_seq, pc_skip;

  always_comb begin
    flags_d = (flags_q & ~alu_mask) | (alu_flags & alu_mask);
    if (tsave_req) flags_d[T_POS] = tsave_val;
    if (iret)      flags_d[I_POS] = 1'b1;
    if (flag_set)      flags_d[flag_sel] = 1'b1;
    else if (flag_clr) flags_d[flag_sel] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;

  assign sreg = flags_q;

  always_comb begin
    tfill_out = tfill_in;
    tfill_out[tfill_pos] = flags_q[T_POS];
  end

  assign br_flag = br_nv ? (flags_q[N_POS] ^ flags_q[V_POS]) : flags_q[br_sel];
  assign br_take = br_req && (br_flag == br_when_set);
  assign sk_take = sk_req && !br_req && (sk_bit == sk_when_set);

  assign off_ext = {{EXT_W{br_off[OFF_W-1]}}, br_off};
  assign pc_seq  = pc_in + PC_W'(1);
  assign pc_skip = pc_in + (sk_long ? PC_W'(3) : PC_W'(2));

  assign pc_next = br_take ? (pc_seq + off_ext) : (sk_take ? pc_skip : pc_seq);
  assign cycles  = (br_take || sk_take) ? 2'd2 : 2'd1;
endmodule

// File: rtl/sreg_branch_unit_chk.sv
module sreg_branch_unit_chk #(
  parameter int PC_W = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic [7:0]      alu_mask,
  input logic            flag_set,
  input logic            flag_clr,
  input logic [2:0]      flag_sel,
  input logic            tsave_req,
  input logic            iret,
  input logic            br_req,
  input logic            sk_req,
  input logic            sk_bit,
  input logic            sk_when_set,
  input logic [PC_W-1:0] pc_in,
  input logic [PC_W-1:0] pc_next,
  input logic [1:0]      cycles,
  input logic [7:0]      sreg
);
  // R1
  idle_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_req && !sk_req) |-> (pc_next == pc_in + PC_W'(1)) && (cycles == 2'd1));

  // R2
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_mask == 8'h00 && !flag_set && !flag_clr && !tsave_req && !iret) |=> $stable(sreg));

  // R3
  set_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set |=> sreg[$past(flag_sel)]);

  // R3
  clr_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !flag_set) |=> !sreg[$past(flag_sel)]);

  // R5
  iret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iret && !(flag_clr && !flag_set && flag_sel == 3'd7)) |=> sreg[7]);

  // R6
  extra_cycle_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cycles == 2'd2) |-> (br_req || sk_req));

  // R8
  skip_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sk_req && !br_req && sk_bit == sk_when_set) |-> cycles == 2'd2);
endmodule

bind sreg_branch_unit sreg_branch_unit_chk #(.PC_W(PC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .alu_mask(alu_mask), .flag_set(flag_set),
  .flag_clr(flag_clr), .flag_sel(flag_sel), .tsave_req(tsave_req), .iret(iret),
  .br_req(br_req), .sk_req(sk_req), .sk_bit(sk_bit), .sk_when_set(sk_when_set),
  .pc_in(pc_in), .pc_next(pc_next), .cycles(cycles), .sreg(sreg)
);

// File: tb/sreg_branch_unit_tb_top.sv
module sreg_branch_unit_tb_top;
  localparam int PCW = 10;
  localparam int OFW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] alu_mask, alu_flags, tfill_in, tfill_out, sreg;
  logic flag_set, flag_clr, tsave_req, tsave_val, iret;
  logic [2:0] flag_sel, tfill_pos, br_sel;
  logic br_req, br_nv, br_when_set, sk_req, sk_bit, sk_when_set, sk_long;
  logic [OFW-1:0] br_off;
  logic [PCW-1:0] pc_in, pc_next;
  logic [1:0] cycles;

  int checks = 0;
  int fails = 0;
  logic [7:0] m_sreg = 8'h00;

  always #2 clk = ~clk;

  sreg_branch_unit #(.PC_W(PCW), .OFF_W(OFW)) dut_i (
    .clk(clk), .rst_n(rst_n), .alu_mask(alu_mask), .alu_flags(alu_flags),
    .flag_set(flag_set), .flag_clr(flag_clr), .flag_sel(flag_sel),
    .tsave_req(tsave_req), .tsave_val(tsave_val), .tfill_in(tfill_in),
    .tfill_pos(tfill_pos), .tfill_out(tfill_out), .iret(iret),
    .br_req(br_req), .br_nv(br_nv), .br_when_set(br_when_set), .br_sel(br_sel),
    .br_off(br_off), .sk_req(sk_req), .sk_bit(sk_bit), .sk_when_set(sk_when_set),
    .sk_long(sk_long), .pc_in(pc_in), .pc_next(pc_next), .cycles(cycles), .sreg(sreg)
  );

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    alu_mask = 0; alu_flags = 0; flag_set = 0; flag_clr = 0; flag_sel = 0;
    tsave_req = 0; tsave_val = 0; tfill_in = 0; tfill_pos = 0; iret = 0;
    br_req = 0; br_nv = 0; br_when_set = 0; br_sel = 0; br_off = 0;
    sk_req = 0; sk_bit = 0; sk_when_set = 0; sk_long = 0;
  endtask

  // inputs set just after a falling edge; one full cycle checked against the model
  task automatic tick();
    int off, pcv, exp_pc;
    bit flag, bt, st;
    logic [7:0] fill, nxt;
    string pctag, stag;
    #1;
    off = int'(br_off);
    if (off >= 64) off = off - 128;
    pcv = int'(pc_in);
    flag = br_nv ? (m_sreg[2] ^ m_sreg[3]) : m_sreg[br_sel];
    bt = br_req && (flag == br_when_set);
    st = sk_req && !br_req && (sk_bit == sk_when_set);
    if (bt) exp_pc = pcv + 1 + off;
    else if (st) exp_pc = pcv + (sk_long ? 3 : 2);
    else exp_pc = pcv + 1;
    exp_pc = ((exp_pc % 1024) + 1024) % 1024;
    if (br_req && sk_req) pctag = "R9";
    else if (br_req) pctag = br_nv ? "R7" : "R6";
    else if (sk_req) pctag = "R8";
    else pctag = "R1";
    cmp(pctag, "pc_next", 32'(pc_next), 32'(exp_pc));
    cmp(pctag, "cycles", 32'(cycles), (bt || st) ? 32'd2 : 32'd1);
    fill = tfill_in;
    fill[tfill_pos] = m_sreg[6];
    cmp("R4", "tfill_out", 32'(tfill_out), 32'(fill));
    if (flag_set || flag_clr) stag = "R3";
    else if (tsave_req) stag = "R4";
    else if (iret) stag = "R5";
    else stag = "R2";
    nxt = m_sreg;
    for (int i = 0; i < 8; i++) if (alu_mask[i]) nxt[i] = alu_flags[i];
    if (tsave_req) nxt[6] = tsave_val;
    if (iret) nxt[7] = 1'b1;
    if (flag_set) nxt[flag_sel] = 1'b1;
    else if (flag_clr) nxt[flag_sel] = 1'b0;
    @(posedge clk);
    m_sreg = nxt;
    @(negedge clk);
    cmp(stag, "sreg", 32'(sreg), 32'(m_sreg));
  endtask

  task automatic load(logic [7:0] v);
    idle(); alu_mask = 8'hFF; alu_flags = v; tick();
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [6:0] offs [5];
    logic [9:0] pcs [3];
    offs[0] = 7'd0; offs[1] = 7'd1; offs[2] = 7'd63; offs[3] = 7'h40; offs[4] = 7'h7F;
    pcs[0] = 10'd0; pcs[1] = 10'd1023; pcs[2] = 10'd500;
    idle(); pc_in = 10'd5;
    @(negedge clk); @(negedge clk);
    // R1 reset state
    cmp("R1", "sreg", 32'(sreg), 32'h0);
    cmp("R1", "pc_next", 32'(pc_next), 32'd6);
    cmp("R1", "cycles", 32'(cycles), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 masked updates
    load(8'h00);
    for (int i = 0; i < 24; i++) begin
      idle(); alu_mask = 8'($urandom); alu_flags = 8'($urandom); tick();
    end
    // R3 set, clear, conflicts
    for (int b = 0; b < 8; b++) begin
      idle(); flag_set = 1; flag_sel = 3'(b); tick();
      idle(); flag_clr = 1; flag_sel = 3'(b); tick();
      idle(); flag_set = 1; flag_sel = 3'(b); alu_mask = 8'hFF; alu_flags = 8'h00; tick();
      idle(); flag_clr = 1; flag_sel = 3'(b); alu_mask = 8'hFF; alu_flags = 8'hFF; tick();
      idle(); flag_set = 1; flag_clr = 1; flag_sel = 3'(b); tick();
    end
    idle(); flag_clr = 1; flag_sel = 3'd6; tsave_req = 1; tsave_val = 1; tick();
    // R4 T store and bit load
    for (int v = 0; v < 2; v++) begin
      idle(); tsave_req = 1; tsave_val = 1'(v); alu_mask = 8'h40; alu_flags = v ? 8'h00 : 8'hFF; tick();
      for (int p = 0; p < 8; p++) begin
        idle(); tfill_pos = 3'(p); tfill_in = 8'h00; tick();
        idle(); tfill_pos = 3'(p); tfill_in = 8'hFF; tick();
      end
    end
    // R5 interrupt return
    load(8'h00);
    idle(); iret = 1; tick();
    idle(); iret = 1; flag_clr = 1; flag_sel = 3'd7; tick();
    idle(); iret = 1; alu_mask = 8'h80; alu_flags = 8'h00; tick();
    // R6 generic branches over all flags, polarities, displacements, wrap points
    for (int pat = 0; pat < 4; pat++) begin
      load(pat == 0 ? 8'h00 : pat == 1 ? 8'hFF : pat == 2 ? 8'h55 : 8'hAA);
      for (int s = 0; s < 8; s++)
        for (int pol = 0; pol < 2; pol++)
          for (int o = 0; o < 5; o++)
            for (int q = 0; q < 3; q++) begin
              idle(); br_req = 1; br_sel = 3'(s); br_when_set = 1'(pol);
              br_off = offs[o]; pc_in = pcs[q]; tick();
            end
    end
    // R7 signed tests with S forced inconsistent
    for (int nv = 0; nv < 4; nv++) begin
      load({3'b000, ~(nv[0] ^ nv[1]), nv[1], nv[0], 2'b00});
      for (int pol = 0; pol < 2; pol++)
        for (int s = 0; s < 8; s++) begin
          idle(); br_req = 1; br_nv = 1; br_sel = 3'(s); br_when_set = 1'(pol);
          br_off = 7'h7E; pc_in = 10'd1; tick();
        end
    end
    // R8 skips
    for (int c = 0; c < 8; c++)
      for (int q = 0; q < 3; q++) begin
        idle(); sk_req = 1; sk_bit = c[0]; sk_when_set = c[1]; sk_long = c[2];
        pc_in = (q == 0) ? 10'd1022 : (q == 1) ? 10'd1023 : 10'd77; tick();
      end
    // R9 branch and skip together
    for (int c = 0; c < 16; c++) begin
      load(c[0] ? 8'h01 : 8'h00);
      idle(); br_req = 1; br_sel = 3'd0; br_when_set = c[1];
      sk_req = 1; sk_bit = c[2]; sk_when_set = c[3]; br_off = 7'h05; pc_in = 10'd200; tick();
    end
    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      idle();
      alu_mask = 8'($urandom); alu_flags = 8'($urandom);
      flag_set = ($urandom % 6) == 0; flag_clr = ($urandom % 6) == 0; flag_sel = 3'($urandom);
      tsave_req = ($urandom % 5) == 0; tsave_val = 1'($urandom);
      tfill_in = 8'($urandom); tfill_pos = 3'($urandom); iret = ($urandom % 7) == 0;
      br_req = ($urandom % 3) == 0; br_nv = 1'($urandom); br_when_set = 1'($urandom);
      br_sel = 3'($urandom); br_off = 7'($urandom);
      sk_req = ($urandom % 3) == 0; sk_bit = 1'($urandom); sk_when_set = 1'($urandom);
      sk_long = 1'($urandom); pc_in = 10'($urandom);
      tick();
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule